// File: doc/BRIEF.md
# Carry-Less Polynomial Fold Unit

This unit advances a 128-bit CRC remainder across a fixed fold distance so it can be merged with the next 128-bit data word. The remainder is split into two 64-bit halves. Each half is carry-less multiplied by its own 64-bit multiplier from a 128-bit fold constant. The two 127-bit products and the data word are then XORed together to give the new remainder. Software or a sequencer picks the constant that matches the wanted distance (128 up to 2048 bits) and presents it with the operands.

A single serial carry-less multiplier handles one multiplier bit per clock and is shared by both products. An operation therefore takes 128 cycles from the accepted start to the done pulse. The bit-order mode decides which physical 64-bit word carries the high polynomial terms. It also decides whether the data bytes are mirrored before the combine, which is needed when bytes enter most-significant-bit first. Operands and mode are captured on the accepted start and are not sampled again.

Top module: `fold_unit`

## Requirements
- R1: While rst_ni is low, acc_o is zero, busy_o is low and done_o is low.
- R2: A start_i seen high at a clock edge while busy_o is low is accepted, and busy_o is high from the next cycle.
- R3: done_o is high for exactly one cycle, 128 cycles after the accepting edge, and busy_o is low in that cycle.
- R4: The result is clmul(acc[127:64], k[127:64]) XOR clmul(acc[63:0], k[63:0]) XOR data', where clmul is a 64x64 carry-less product placed in bits 126:0 with bit 127 zero. k=0 gives data' alone.
- R5: With lsb_first_i=0 (msb-first), data' is data_i with its 16 bytes mirrored: bits [8i+7:8i] go to byte 15-i. With lsb_first_i=1, data' is data_i unchanged.
- R6: With lsb_first_i=1, the high polynomial half is the physical low word, so both half selectors are inverted. The products pair the same physical words, and the result still matches R4.
- R7: start_i while busy_o is high is ignored. The running result, its latency and the number of done pulses do not change.
- R8: acc_i, data_i, k_i and lsb_first_i are captured at the accepting edge. Changes to them during the operation have no effect, and acc_o changes only in a cycle where done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a fold; accepted only when idle |
| lsb_first_i | input | 1 | 1: lsb-first bit order, 0: msb-first with data byte mirroring |
| acc_i | input | 128 | Remainder to fold forward |
| data_i | input | 128 | Next message word |
| k_i | input | 128 | Fold constant, one 64-bit multiplier per half |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | 128 | Folded remainder, held until the next completion |

## Verification
The bench goes after operand extremes:
- All-ones multipliers drive the top product bit 126. A multiplier that dropped its last shift step would lose that bit.
- A zero constant must return only the prepared data. A product that leaked stale state would show there.

Running the same operands in both bit orders exposes a wrong byte mirror or a swapped half pairing, because the results must differ only by the data reflection. A second start and mode or operand changes in mid-flight check that nothing is re-sampled. A design that restarts on a busy start would show an extra done pulse or a late one. A reset during an operation must clear the result and abandon the pulse.

// File: rtl/fold_pkg.sv
package fold_pkg;
  localparam int unsigned DEF_HALF_W = 64;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/fold_operand_sel.sv
module fold_operand_sel
  import fold_pkg::*;
#(
  parameter int unsigned HALF_W = DEF_HALF_W
) (
  input  logic                lsb_i,
  input  logic [2*HALF_W-1:0] acc_i,
  input  logic [2*HALF_W-1:0] k_i,
  input  logic [2*HALF_W-1:0] data_i,
  output logic [HALF_W-1:0]   a_first_o,
  output logic [HALF_W-1:0]   k_first_o,
  output logic [HALF_W-1:0]   a_second_o,
  output logic [HALF_W-1:0]   k_second_o,
  output logic [2*HALF_W-1:0] data_o
);
  localparam int unsigned NBYTES = (2 * HALF_W) / 8;

  logic [HALF_W-1:0]   acc_h [2];
  logic [HALF_W-1:0]   k_h   [2];
  logic                hi_idx;
  logic                lo_idx;
  logic [2*HALF_W-1:0] data_rev;

  assign acc_h[0] = acc_i[HALF_W-1:0];
  assign acc_h[1] = acc_i[2*HALF_W-1:HALF_W];
  assign k_h[0]   = k_i[HALF_W-1:0];
  assign k_h[1]   = k_i[2*HALF_W-1:HALF_W];

  // lsb-first order keeps the high polynomial terms in the physical low word
  assign hi_idx = HALF_HI ^ lsb_i;
  assign lo_idx = ~hi_idx;

  assign a_first_o  = acc_h[hi_idx];
  assign k_first_o  = k_h[hi_idx];
  assign a_second_o = acc_h[lo_idx];
  assign k_second_o = k_h[lo_idx];

  for (genvar g = 0; g < NBYTES; g++) begin : g_mirror
    assign data_rev[8*g +: 8] = data_i[8*(NBYTES-1-g) +: 8];
  end

  assign data_o = lsb_i ? data_i : data_rev;
endmodule

// File: rtl/clmul_serial.sv
module clmul_serial
  import fold_pkg::*;
#(
  parameter int unsigned HALF_W = DEF_HALF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [HALF_W-1:0]   a_first_i,
  input  logic [HALF_W-1:0]   k_first_i,
  input  logic [HALF_W-1:0]   a_second_i,
  input  logic [HALF_W-1:0]   k_second_i,
  output logic                busy_o,
  output logic                fin_o,
  output logic [2*HALF_W-1:0] sum_o
);
  localparam int unsigned STEPS = 2 * HALF_W;
  localparam int unsigned CNT_W = $clog2(STEPS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEPS - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF_W - 1);

  logic                busy_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [2*HALF_W-1:0] a_sh_q;
  logic [HALF_W-1:0]   k_sh_q;
  logic [HALF_W-1:0]   a2_q;
  logic [HALF_W-1:0]   k2_q;
  logic [2*HALF_W-1:0] prod_q;
  logic [2*HALF_W-1:0] term;
  logic [2*HALF_W-1:0] prod_d;
  logic                accept;
  logic                half_end;

  assign accept   = start_i && !busy_q;
  assign half_end = busy_q && (cnt_q == CNT_HALF);
  assign term     = k_sh_q[0] ? a_sh_q : '0;
  assign prod_d   = prod_q ^ term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      a_sh_q <= '0;
      k_sh_q <= '0;
      a2_q   <= '0;
      k2_q   <= '0;
      prod_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      a_sh_q <= {{HALF_W{1'b0}}, a_first_i};
      k_sh_q <= k_first_i;
      a2_q   <= a_second_i;
      k2_q   <= k_second_i;
      prod_q <= '0;
    end else if (busy_q) begin
      prod_q <= prod_d;
      cnt_q  <= cnt_q + 1'b1;
      if (half_end) begin
        a_sh_q <= {{HALF_W{1'b0}}, a2_q};
        k_sh_q <= k2_q;
      end else begin
        a_sh_q <= a_sh_q << 1;
        k_sh_q <= k_sh_q >> 1;
      end
      if (cnt_q == CNT_LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == CNT_LAST);
  assign sum_o  = prod_d;

  p_fin_ends_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_o);
  p_busy_runs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !fin_o |=> busy_o && $stable(a2_q) && $stable(k2_q));
endmodule

// File: rtl/fold_unit.sv
module fold_unit
  import fold_pkg::*;
#(
  parameter int unsigned HALF_W = DEF_HALF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                lsb_first_i,
  input  logic [2*HALF_W-1:0] acc_i,
  input  logic [2*HALF_W-1:0] data_i,
  input  logic [2*HALF_W-1:0] k_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*HALF_W-1:0] acc_o
);
  localparam int unsigned W = 2 * HALF_W;

  logic [HALF_W-1:0] a_first, k_first, a_second, k_second;
  logic [W-1:0]      data_sel;
  logic [W-1:0]      data_q;
  logic [W-1:0]      acc_q;
  logic [W-1:0]      sum;
  logic              done_q;
  logic              busy;
  logic              fin;
  logic              accept;

  fold_operand_sel #(.HALF_W(HALF_W)) i_sel (
    .lsb_i      (lsb_first_i),
    .acc_i      (acc_i),
    .k_i        (k_i),
    .data_i     (data_i),
    .a_first_o  (a_first),
    .k_first_o  (k_first),
    .a_second_o (a_second),
    .k_second_o (k_second),
    .data_o     (data_sel)
  );

  clmul_serial #(.HALF_W(HALF_W)) i_mul (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .a_first_i  (a_first),
    .k_first_i  (k_first),
    .a_second_i (a_second),
    .k_second_i (k_second),
    .busy_o     (busy),
    .fin_o      (fin),
    .sum_o      (sum)
  );

  assign accept = start_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (accept) data_q <= data_sel;
      if (fin) acc_q <= sum ^ data_q;  // three-way combine
      done_q <= fin;
    end
  end

  assign busy_o = busy;
  assign done_o = done_q;
  assign acc_o  = acc_q;

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_acc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_o) |-> done_o);
  p_top_bit_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> (acc_o[W-1] == data_q[W-1]));
endmodule

// File: tb/test_fold_unit.sv
module test_fold_unit;
  typedef struct packed {
    logic [127:0] acc;
    logic [127:0] data;
    logic [127:0] k;
    logic         lsb;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{128'h0, 128'h00112233_44556677_8899aabb_ccddeeff, 128'h0, 1'b0},
    '{{128{1'b1}}, 128'h0, {128{1'b1}}, 1'b1},
    '{{64'h8000_0000_0000_0000, 64'h1}, 128'h0, {64'h8000_0000_0000_0000, 64'h1}, 1'b0},
    '{128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 128'hdead_beef_0bad_f00d_1234_5678_9abc_def0,
      128'hb4e5_b025_f7ff_ffff_8f35_2d95_7c91_0001, 1'b0},
    '{128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 128'hdead_beef_0bad_f00d_1234_5678_9abc_def0,
      128'hb4e5_b025_f7ff_ffff_8f35_2d95_7c91_0001, 1'b1},
    '{128'h5555_aaaa_3333_cccc_0f0f_f0f0_00ff_ff00, 128'h8000_0000_0000_0000_0000_0000_0000_0001,
      128'h0000_0001_0000_0001_c000_0000_0000_0003, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         lsb = 1'b0;
  logic [127:0] acc_in = '0;
  logic [127:0] data_in = '0;
  logic [127:0] k_in = '0;
  logic         busy, done;
  logic [127:0] acc_out;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fold_unit i_fold_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lsb_first_i(lsb),
    .acc_i(acc_in), .data_i(data_in), .k_i(k_in),
    .busy_o(busy), .done_o(done), .acc_o(acc_out)
  );

  function automatic logic [127:0] ref_clmul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] r = '0;
    for (int i = 0; i < 64; i++) if (b[i]) r ^= ({64'h0, a} << i);
    return r;
  endfunction

  function automatic logic [127:0] ref_fold(input vec_t v);
    logic [127:0] d;
    if (v.lsb) d = v.data;
    else for (int i = 0; i < 16; i++) d[8*i +: 8] = v.data[8*(15-i) +: 8];
    return ref_clmul(v.acc[127:64], v.k[127:64]) ^ ref_clmul(v.acc[63:0], v.k[63:0]) ^ d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    acc_in = v.acc; data_in = v.data; k_in = v.k; lsb = v.lsb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat;
    logic [127:0] exp, held;
    vec_t alt;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(acc_out == '0 && !busy && !done, "R1 reset", {126'h0, busy, done} | acc_out, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R4 R5 R6 R2 R3
    for (int n = 0; n < NV; n++) begin
      launch(VECS[n]);
      chk(busy, "R2 busy after accept", 128'(busy), 128'(1));
      wait_done(lat);
      exp = ref_fold(VECS[n]);
      chk(lat == 128, "R3 latency", 128'(lat), 128'(128));
      chk(acc_out == exp, VECS[n].lsb ? "R6 lsb-first result" : "R4 R5 msb-first result", acc_out, exp);
      chk(!busy, "R3 idle at done", 128'(busy), 128'(0));
      @(negedge clk);
      chk(!done && acc_out == exp, "R3 R8 single pulse, held result", {127'h0, done}, 128'(0));
    end

    // R5: msb vs lsb differ only by data mirroring
    chk(ref_fold(VECS[3]) != ref_fold(VECS[4]), "R5 modes differ", ref_fold(VECS[3]), ref_fold(VECS[4]));

    // R7 R8: start and input changes while busy are ignored
    launch(VECS[3]);
    exp = ref_fold(VECS[3]);
    alt = VECS[5];
    repeat (20) @(negedge clk);
    acc_in = alt.acc; data_in = alt.data; k_in = alt.k; lsb = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk(lat == 107, "R7 latency with busy start", 128'(lat), 128'(107));
    chk(acc_out == exp, "R8 captured operands and mode", acc_out, exp);
    held = acc_out;
    lat = 0;
    repeat (140) begin
      @(negedge clk);
      if (done || busy) lat++;
    end
    chk(lat == 0, "R7 no extra done", 128'(lat), 128'(0));
    chk(acc_out == held, "R8 result held while idle", acc_out, held);

    // R4: zero constant returns data only
    alt = '{{128{1'b1}}, 128'hfeed_0000_0000_0000_0000_0000_0000_0001, 128'h0, 1'b1};
    launch(alt);
    wait_done(lat);
    chk(acc_out == alt.data, "R4 zero constant", acc_out, alt.data);

    // R1: reset mid-operation
    launch(VECS[1]);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(acc_out == '0 && !busy && !done, "R1 reset mid-run", acc_out, '0);
    rst_n = 1'b1;
    repeat (140) @(negedge clk);
    chk(!done && !busy, "R1 run abandoned", {126'h0, busy, done}, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule